// File: doc/BRIEF.md
# Inter-Processor Interrupt Hub with Shootdown Tracking

This block carries inter-processor interrupts between the cores of a multicore cluster. Any core may post a 2-bit interrupt code either to one chosen core or to every core except itself. Each receiving core keeps a small bitmask of pending codes and sees an interrupt line raised while any bit of that mask is set. It clears bits by writing ones to them.

Translation-invalidation requests also carry a mapping descriptor: a 32-bit virtual page number and an 8-bit address-space id. Each receiving core stores these in a bounded queue of its own. The core can read any stored entry by index and can discard the whole queue with a single drain pulse. A request aimed at a full queue is refused for that core and reported to the sender.

An accepted invalidation request opens a round. The addressed cores are held until the sender releases them. Each held core acknowledges once it has invalidated its entries. When all of them have acknowledged, the sender sees a done flag and may then issue the release.

Posting uses a valid/ready handshake for each sender. A sender holds its valid signal and all request fields steady until it sees ready high at a rising clock edge; that edge accepts the request. At most one request is accepted per cycle. While a round is open, invalidation requests are held back by keeping ready low, and other codes still flow. All other pins are plain level or pulse signals.

Top module: `ipi_hub`

## Requirements
- R1: An accepted post with code c (0 panic, 1 go offline, 2 threads runnable, 3 invalidate) sets bit c of the addressed core's 4-bit pending mask one cycle later, and that core's interrupt line goes high.
- R2: A broadcast post (bcast=1) reaches every core except the sender; the target field is ignored and the sender's own mask is untouched.
- R3: An accepted code-3 post stores its descriptor in the target queue at index equal to that queue's count and increments the count; entries read back at those indices.
- R4: A code-3 post to a core whose count equals DEPTH writes nothing to that core: its count, entries and pending bit stay unchanged, no round is opened for it, and the sender's overflow line pulses high for one cycle, the cycle after acceptance.
- R5: When several senders are valid in the same cycle, only the lowest-indexed eligible sender sees ready; the others wait.
- R6: Writing clr_we with clr_bits clears exactly the pending bits given as ones; the interrupt line falls once the mask is zero.
- R7: A drain pulse resets the core's queue count to zero.
- R8: While a round is open, a code-3 post is stalled (ready low); posts of other codes are still accepted.
- R9: An accepted code-3 post raises hold for every core that received its descriptor. The sender's done bit rises only in the cycle after the last of those cores has acknowledged.
- R10: A release from the sender while its done bit is high clears done and every hold bit in the next cycle; a release before done is ignored.
- R11: After reset, all pending masks, interrupt lines, counts, hold, done and overflow outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | N_CORES | Per-sender request valid |
| post_ready | output | N_CORES | Per-sender accept (grant) |
| post_code | input | 2*N_CORES | Per-sender interrupt code |
| post_bcast | input | N_CORES | Per-sender broadcast select |
| post_target | input | IW*N_CORES | Per-sender target index for a unicast post |
| post_vpn | input | 32*N_CORES | Per-sender descriptor page number |
| post_asid | input | 8*N_CORES | Per-sender descriptor address-space id |
| ovf_err | output | N_CORES | Per-sender one-cycle overflow report |
| pend_mask | output | 4*N_CORES | Per-core pending code mask |
| irq | output | N_CORES | Per-core interrupt line |
| clr_we | input | N_CORES | Per-core clear strobe |
| clr_bits | input | 4*N_CORES | Per-core bits to clear |
| q_count | output | CW*N_CORES | Per-core queue entry count |
| rd_idx | input | QIW*N_CORES | Per-core queue read index |
| rd_vpn | output | 32*N_CORES | Page number at the read index |
| rd_asid | output | 8*N_CORES | Address-space id at the read index |
| q_drain | input | N_CORES | Per-core queue drain pulse |
| ack | input | N_CORES | Per-core invalidation done acknowledge |
| hold | output | N_CORES | Per-core held-in-round indication |
| sd_done | output | N_CORES | Done flag, high only for the round owner |
| sd_release | input | N_CORES | Per-core round release |

## Verification
The bench drives unicast and broadcast posts from different senders and checks that the pending masks of the target cores and of the sender differ as expected. Simultaneous requests from non-adjacent senders show whether the grant goes to the lowest index. For invalidation rounds, the bench sends a unicast round and a three-target broadcast round with partial acknowledgements, which separates "some acked" from "all acked". A round is also started alongside another sender's stalled invalidation request. Sixteen sequential rounds fill one queue, and a seventeenth post then checks the refusal path, so the boundary between the last accepted entry and the rejected one is checked.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned VPN_W  = 32;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned CODE_W = 2;
  localparam int unsigned NCODE  = 4;

  typedef enum logic [CODE_W-1:0] {
    IPI_HALT    = 2'd0,
    IPI_OFFLINE = 2'd1,
    IPI_WAKE    = 2'd2,
    IPI_SHOOT   = 2'd3
  } ipi_code_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
  } map_desc_t;
endpackage

// File: rtl/ipi_prio_arb.sv
module ipi_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end
endmodule

// File: rtl/ipi_target_slot.sv
module ipi_target_slot
  import ipi_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned QIW  = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              post_en,
  input  ipi_code_e         code,
  input  map_desc_t         desc,
  input  logic              clr_we,
  input  logic [NCODE-1:0]  clr_bits,
  input  logic              drain,
  input  logic [QIW-1:0]    rd_idx,
  output logic [NCODE-1:0]  pend,
  output logic              irq,
  output logic [CW-1:0]     count,
  output logic              full,
  output map_desc_t         rd_desc
);
  map_desc_t        mem [DEPTH];
  logic [CW-1:0]    base;
  logic [NCODE-1:0] set_bits, clr_eff;
  logic             append;

  assign append   = post_en && (code == IPI_SHOOT);
  assign base     = drain ? '0 : count;
  assign set_bits = post_en ? (NCODE'(1) << code) : '0;
  assign clr_eff  = clr_we ? clr_bits : '0;
  assign full     = (count == CW'(DEPTH));
  assign irq      = |pend;
  assign rd_desc  = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      count <= '0;
    end else begin
      pend <= (pend & ~clr_eff) | set_bits;
      if (append)     count <= base + CW'(1);
      else if (drain) count <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (append) mem[base[QIW-1:0]] <= desc;
  end
endmodule

// File: rtl/ipi_sd_tracker.sv
module ipi_sd_tracker #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_en,
  input  logic [IW-1:0] open_owner,
  input  logic [N-1:0]  open_mask,
  input  logic [N-1:0]  ack,
  input  logic [N-1:0]  rel,
  output logic          busy,
  output logic [N-1:0]  hold,
  output logic [N-1:0]  done
);
  logic [IW-1:0] owner;
  logic [N-1:0]  wait_m, acked;
  logic          all_in;

  assign all_in = busy && (acked == wait_m);
  assign hold   = wait_m;
  assign done   = all_in ? (N'(1) << owner) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      owner  <= '0;
      wait_m <= '0;
      acked  <= '0;
    end else if (open_en) begin
      busy   <= 1'b1;
      owner  <= open_owner;
      wait_m <= open_mask;
      acked  <= '0;
    end else if (all_in && rel[owner]) begin
      busy   <= 1'b0;
      wait_m <= '0;
      acked  <= '0;
    end else if (busy) begin
      acked <= acked | (ack & wait_m);
    end
  end
endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned DEPTH   = 16,
  localparam int unsigned IW  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned QIW = $clog2(DEPTH),
  localparam int unsigned CW  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CORES-1:0]          post_valid,
  output logic [N_CORES-1:0]          post_ready,
  input  logic [CODE_W*N_CORES-1:0]   post_code,
  input  logic [N_CORES-1:0]          post_bcast,
  input  logic [IW*N_CORES-1:0]       post_target,
  input  logic [VPN_W*N_CORES-1:0]    post_vpn,
  input  logic [ASID_W*N_CORES-1:0]   post_asid,
  output logic [N_CORES-1:0]          ovf_err,
  output logic [NCODE*N_CORES-1:0]    pend_mask,
  output logic [N_CORES-1:0]          irq,
  input  logic [N_CORES-1:0]          clr_we,
  input  logic [NCODE*N_CORES-1:0]    clr_bits,
  output logic [CW*N_CORES-1:0]       q_count,
  input  logic [QIW*N_CORES-1:0]      rd_idx,
  output logic [VPN_W*N_CORES-1:0]    rd_vpn,
  output logic [ASID_W*N_CORES-1:0]   rd_asid,
  input  logic [N_CORES-1:0]          q_drain,
  input  logic [N_CORES-1:0]          ack,
  output logic [N_CORES-1:0]          hold,
  output logic [N_CORES-1:0]          sd_done,
  input  logic [N_CORES-1:0]          sd_release
);
  logic [N_CORES-1:0] elig, grant, full, hit, wr_mask;
  logic               busy, accept, is_sd, reject;
  logic [IW-1:0]      sel;
  ipi_code_e          sel_code;
  map_desc_t          sel_desc;

  for (genvar i = 0; i < N_CORES; i++) begin : g_elig
    assign elig[i] = post_valid[i] &&
      !((post_code[i*CODE_W +: CODE_W] == IPI_SHOOT) && busy);
  end

  ipi_prio_arb #(.N(N_CORES)) arb_i (.req(elig), .gnt(grant));

  assign post_ready = grant;
  assign accept     = |grant;

  always_comb begin
    sel = '0;
    for (int i = N_CORES - 1; i >= 0; i--) begin
      if (grant[i]) sel = IW'(i);
    end
  end

  assign sel_code      = ipi_code_e'(post_code[sel*CODE_W +: CODE_W]);
  assign sel_desc.vpn  = post_vpn[sel*VPN_W +: VPN_W];
  assign sel_desc.asid = post_asid[sel*ASID_W +: ASID_W];
  assign is_sd         = (sel_code == IPI_SHOOT);
  assign hit     = post_bcast[sel] ? ~(N_CORES'(1) << sel)
                                   : (N_CORES'(1) << post_target[sel*IW +: IW]);
  assign wr_mask = !accept ? '0 : (is_sd ? (hit & ~full) : hit);
  assign reject  = accept && is_sd && |(hit & full);

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_err <= '0;
    else        ovf_err <= reject ? (N_CORES'(1) << sel) : '0;
  end

  for (genvar j = 0; j < N_CORES; j++) begin : g_slot
    map_desc_t rdd;
    ipi_target_slot #(.DEPTH(DEPTH)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .post_en  (wr_mask[j]),
      .code     (sel_code),
      .desc     (sel_desc),
      .clr_we   (clr_we[j]),
      .clr_bits (clr_bits[j*NCODE +: NCODE]),
      .drain    (q_drain[j]),
      .rd_idx   (rd_idx[j*QIW +: QIW]),
      .pend     (pend_mask[j*NCODE +: NCODE]),
      .irq      (irq[j]),
      .count    (q_count[j*CW +: CW]),
      .full     (full[j]),
      .rd_desc  (rdd)
    );
    assign rd_vpn[j*VPN_W +: VPN_W]    = rdd.vpn;
    assign rd_asid[j*ASID_W +: ASID_W] = rdd.asid;
  end

  ipi_sd_tracker #(.N(N_CORES)) trk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_en    (accept && is_sd && |wr_mask),
    .open_owner (sel),
    .open_mask  (wr_mask),
    .ack        (ack),
    .rel        (sd_release),
    .busy       (busy),
    .hold       (hold),
    .done       (sd_done)
  );
endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned DEPTH   = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_CORES-1:0]     post_valid,
  input logic [N_CORES-1:0]     post_ready,
  input logic [2*N_CORES-1:0]   post_code,
  input logic [N_CORES-1:0]     ovf_err,
  input logic [CW*N_CORES-1:0]  q_count,
  input logic [N_CORES-1:0]     q_drain,
  input logic [N_CORES-1:0]     hold,
  input logic [N_CORES-1:0]     sd_done,
  input logic [N_CORES-1:0]     sd_release
);
  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_ready));

  assert_done_single_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|sd_done) |-> ($countones(sd_done) == 1 && |hold));

  assert_release_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sd_release & sd_done)) |=> (sd_done == '0 && hold == '0));

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      q_count[i*CW +: CW] <= CW'(DEPTH));

    assert_drain_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_drain[i] |=> (q_count[i*CW +: CW] <= CW'(1)));

    assert_ovf_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err[i] |-> $past(post_ready[i]));

    assert_sd_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (post_valid[i] && post_code[i*2 +: 2] == 2'd3 && |hold) |-> !post_ready[i]);
  end
endmodule

bind ipi_hub ipi_hub_chk #(.N_CORES(N_CORES), .DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .post_valid (post_valid),
  .post_ready (post_ready),
  .post_code  (post_code),
  .ovf_err    (ovf_err),
  .q_count    (q_count),
  .q_drain    (q_drain),
  .hold       (hold),
  .sd_done    (sd_done),
  .sd_release (sd_release)
);

// File: tb/ipi_hub_tb_top.sv
`timescale 1ns/1ps
module ipi_hub_tb_top;
  localparam int N  = 4;
  localparam int D  = 16;
  localparam int IW = 2;
  localparam int QW = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    post_valid = '0, post_bcast = '0;
  logic [2*N-1:0]  post_code = '0;
  logic [IW*N-1:0] post_target = '0;
  logic [32*N-1:0] post_vpn = '0;
  logic [8*N-1:0]  post_asid = '0;
  logic [N-1:0]    post_ready, ovf_err, irq, hold, sd_done;
  logic [4*N-1:0]  pend_mask;
  logic [N-1:0]    clr_we = '0, q_drain = '0, ack = '0, sd_release = '0;
  logic [4*N-1:0]  clr_bits = '0;
  logic [CW*N-1:0] q_count;
  logic [QW*N-1:0] rd_idx = '0;
  logic [32*N-1:0] rd_vpn;
  logic [8*N-1:0]  rd_asid;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ipi_hub #(.N_CORES(N), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_ready(post_ready),
    .post_code(post_code), .post_bcast(post_bcast), .post_target(post_target),
    .post_vpn(post_vpn), .post_asid(post_asid), .ovf_err(ovf_err),
    .pend_mask(pend_mask), .irq(irq), .clr_we(clr_we), .clr_bits(clr_bits),
    .q_count(q_count), .rd_idx(rd_idx), .rd_vpn(rd_vpn), .rd_asid(rd_asid),
    .q_drain(q_drain), .ack(ack), .hold(hold), .sd_done(sd_done),
    .sd_release(sd_release)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pm(input int t);
    return pend_mask[t*4 +: 4];
  endfunction

  function automatic logic [CW-1:0] cnt(input int t);
    return q_count[t*CW +: CW];
  endfunction

  task automatic do_post(input int s, input int code, input bit bc, input int t,
                         input logic [31:0] v, input logic [7:0] a);
    @(negedge clk);
    post_code[s*2 +: 2]    = 2'(code);
    post_bcast[s]          = bc;
    post_target[s*IW +: IW] = IW'(t);
    post_vpn[s*32 +: 32]   = v;
    post_asid[s*8 +: 8]    = a;
    post_valid[s]          = 1'b1;
    #1;
    while (!post_ready[s]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 post_valid[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clear(input int t, input logic [3:0] b);
    @(negedge clk);
    clr_we[t] = 1'b1;
    clr_bits[t*4 +: 4] = b;
    @(negedge clk);
    clr_we[t] = 1'b0;
  endtask

  task automatic pulse_ack(input logic [N-1:0] m);
    @(negedge clk);
    ack = m;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic do_release(input int c);
    @(negedge clk);
    sd_release[c] = 1'b1;
    @(negedge clk);
    sd_release = '0;
  endtask

  task automatic do_drain(input int t);
    @(negedge clk);
    q_drain[t] = 1'b1;
    @(negedge clk);
    q_drain[t] = 1'b0;
  endtask

  task automatic t_reset;
    check(pend_mask == '0, "R11 pend", pend_mask, 0);
    check(irq == '0, "R11 irq", irq, 0);
    check(q_count == '0, "R11 count", q_count, 0);
    check(hold == '0 && sd_done == '0 && ovf_err == '0, "R11 round", {hold, sd_done, ovf_err}, 0);
  endtask

  task automatic t_unicast;
    do_post(0, 1, 0, 2, 0, 0);
    check(pm(2) == 4'b0010, "R1 pend core2", pm(2), 4'b0010);
    check(irq == 4'b0100, "R1 irq", irq, 4'b0100);
    do_clear(2, 4'b0010);
    check(pm(2) == 4'b0000 && irq[2] == 1'b0, "R6 full clear", {irq[2], pm(2)}, 0);
    do_post(3, 0, 0, 1, 0, 0);
    do_post(3, 2, 0, 1, 0, 0);
    check(pm(1) == 4'b0101, "R1 two codes", pm(1), 4'b0101);
    do_clear(1, 4'b0001);
    check(pm(1) == 4'b0100 && irq[1], "R6 partial clear", pm(1), 4'b0100);
    do_clear(1, 4'b1111);
    check(irq == '0, "R6 irq low", irq, 0);
  endtask

  task automatic t_broadcast;
    do_post(1, 2, 1, 1, 0, 0);
    check(pm(0) == 4'b0100 && pm(2) == 4'b0100 && pm(3) == 4'b0100,
          "R2 others", pend_mask, 16'h4404);
    check(pm(1) == 4'b0000, "R2 sender untouched", pm(1), 0);
    for (int t = 0; t < N; t++) do_clear(t, 4'b1111);
  endtask

  task automatic t_arb;
    @(negedge clk);
    post_code[2 +: 2] = 2'd2; post_target[IW +: IW] = '0;   post_bcast[1] = 0;
    post_code[6 +: 2] = 2'd0; post_target[3*IW +: IW] = '0; post_bcast[3] = 0;
    post_valid[1] = 1'b1; post_valid[3] = 1'b1;
    #1 check(post_ready == 4'b0010, "R5 lowest first", post_ready, 4'b0010);
    @(posedge clk);
    #1 post_valid[1] = 1'b0;
    #1 check(post_ready == 4'b1000, "R5 next sender", post_ready, 4'b1000);
    @(posedge clk);
    #1 post_valid[3] = 1'b0;
    @(negedge clk);
    check(pm(0) == 4'b0101, "R5 both delivered", pm(0), 4'b0101);
    do_clear(0, 4'b1111);
  endtask

  task automatic t_rounds;
    do_post(0, 3, 0, 2, 32'hABCD_0001, 8'h05);
    check(cnt(2) == 1, "R3 count", cnt(2), 1);
    rd_idx[2*QW +: QW] = 0;
    #1 check(rd_vpn[64 +: 32] == 32'hABCD_0001 && rd_asid[16 +: 8] == 8'h05,
             "R3 entry0", {rd_vpn[64 +: 32], rd_asid[16 +: 8]}, 40'hABCD000105);
    check(pm(2) == 4'b1000, "R1 shoot bit", pm(2), 4'b1000);
    check(hold == 4'b0100 && sd_done == '0, "R9 hold", {hold, sd_done}, 8'h40);
    // stalled code-3 from core1 while round open
    @(negedge clk);
    post_code[2 +: 2] = 2'd3; post_bcast[1] = 0; post_target[IW +: IW] = 2'd3;
    post_valid[1] = 1'b1;
    #1 check(!post_ready[1], "R8 stall", post_ready, 0);
    @(negedge clk);
    #1 check(!post_ready[1], "R8 stall held", post_ready, 0);
    post_valid[1] = 1'b0;
    do_post(1, 2, 0, 3, 0, 0);
    check(pm(3) == 4'b0100, "R8 other code passes", pm(3), 4'b0100);
    do_clear(3, 4'b1111);
    do_release(0);
    check(hold == 4'b0100, "R10 early release ignored", hold, 4'b0100);
    pulse_ack(4'b0100);
    check(sd_done == 4'b0001, "R9 done", sd_done, 1);
    do_release(0);
    check(sd_done == '0 && hold == '0, "R10 release", {hold, sd_done}, 0);
    // broadcast round from core3
    do_post(3, 3, 1, 0, 32'h0000_7777, 8'h21);
    check(hold == 4'b0111, "R9 bcast hold", hold, 4'b0111);
    check(cnt(2) == 2, "R3 append", cnt(2), 2);
    rd_idx[2*QW +: QW] = 1;
    #1 check(rd_vpn[64 +: 32] == 32'h7777 && rd_asid[16 +: 8] == 8'h21,
             "R3 entry1", rd_vpn[64 +: 32], 32'h7777);
    pulse_ack(4'b0011);
    check(sd_done == '0, "R9 partial ack", sd_done, 0);
    pulse_ack(4'b0100);
    check(sd_done == 4'b1000, "R9 all acked", sd_done, 4'b1000);
    do_release(3);
    check(hold == '0, "R10 bcast release", hold, 0);
    do_drain(2);
    check(cnt(2) == 0, "R7 drain", cnt(2), 0);
    for (int t = 0; t < N; t++) do_clear(t, 4'b1111);
  endtask

  task automatic t_overflow;
    do_drain(1);
    check(cnt(1) == 0, "R7 drain core1", cnt(1), 0);
    for (int k = 0; k < D; k++) begin
      do_post(0, 3, 0, 1, 32'(100 + k), 8'(k));
      pulse_ack(4'b0010);
      do_release(0);
    end
    check(cnt(1) == 5'(D), "R3 full count", cnt(1), D);
    do_clear(1, 4'b1111);
    do_post(0, 3, 0, 1, 32'hDEAD, 8'hEE);
    check(ovf_err == 4'b0001, "R4 overflow flag", ovf_err, 1);
    check(cnt(1) == 5'(D), "R4 count unchanged", cnt(1), D);
    check(hold == '0 && pm(1) == 4'b0000, "R4 no round no bit", {hold, pm(1)}, 0);
    rd_idx[QW +: QW] = 4'(D - 1);
    #1 check(rd_vpn[32 +: 32] == 32'(100 + D - 1), "R4 last entry intact",
             rd_vpn[32 +: 32], 100 + D - 1);
    @(negedge clk);
    check(ovf_err == '0, "R4 one-cycle pulse", ovf_err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unicast();
    t_broadcast();
    t_arb();
    t_rounds();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule